// File: doc/BRIEF.md
# Deferred Condition Flag Evaluator

This unit rebuilds the four arithmetic status flags (negative, zero, overflow, carry) after an instruction has already finished. The datapath saves only three things when it executes a flag-setting instruction: a class code naming the kind of operation, the result word, and the second (source) operand. When the flags are actually needed, for a conditional branch or a status register read, these saved values are presented to this unit. It recovers the missing first operand where the class needs it and derives carry and overflow by the rule that fits that class.

Nine class codes are understood: direct copy, logic, add, subtract, byte compare, word compare, add with extend, subtract with extend and shift. For the two extend classes, the zero flag is merged with the previous zero flag so that a zero test spans several words of a multi-precision operation. The flags are captured in a register one cycle after a request and packed into a 5-bit vector that matches the low bits of a status register. An unknown class code clears the flags and raises an error strobe.

Top module: `lazy_ccr_eval`

## Requirements
- R1: While reset is asserted and right after it, `ccr_o` is 0 and `bad_kind_o` is 0.
- R2: A request (`eval_i` high at a rising edge) updates `ccr_o` at that edge. While `eval_i` is low, `ccr_o` keeps its value whatever the other inputs do.
- R3: `ccr_o` is packed as bit 4 = extend placeholder (always 0), bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C. Class codes on `kind_i` are: 0 copy, 1 logic, 2 add, 3 subtract, 4 byte compare, 5 word compare, 6 add-extend, 7 subtract-extend, 8 shift. For class 0, `ccr_o[3:0]` is `res_i[3:0]`.
- R4: In every class except 0, Z is set exactly when the result at the class width is zero, and N is the top bit of that result, so N and Z are never both set. For class 1, V and C are 0.
- R5: For add, C is set when `res_i` is unsigned-less than `src_i`. V is the sign overflow of the addition (res − src) + src.
- R6: For subtract, the first operand is rebuilt as res + src. C is set when that value is unsigned-less than `src_i`. V is the sign overflow of (res + src) − src.
- R7: Byte and word compare apply the subtract rule to the low 8 and low 16 bits only. N, Z, V and C are taken at that width, and the upper bits of both inputs have no effect.
- R8: For add-extend, C is set when `res_i` ≤ `src_i` unsigned. V is the sign overflow of the addition whose first operand is res − src − 1.
- R9: For subtract-extend, the first operand is rebuilt as res + src + 1. C is set when that value ≤ `src_i` unsigned. V uses the same sign rule as subtract.
- R10: For shift, C is set when `src_i` is non-zero and V is 0.
- R11: For classes 6 and 7 only, Z is the new zero result ANDed with `zprev_i`. Z can be cleared but never newly set.
- R12: A request with a class code of 9 or above loads 0 into `ccr_o` and pulses `bad_kind_o` for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_i | input | 1 | Request to evaluate the saved operands |
| kind_i | input | KW (4) | Saved operation class code |
| res_i | input | DW (32) | Saved result word |
| src_i | input | DW (32) | Saved source operand |
| zprev_i | input | 1 | Previous Z flag, used by the extend classes |
| ccr_o | output | 5 | Packed flags {X placeholder, N, Z, V, C} |
| bad_kind_o | output | 1 | One-cycle strobe after an unknown class code |

## Verification
Random result and source words are mixed with words clustered near zero, near the sign boundary and at all-ones. Each class therefore sees zero, negative, carry and overflow outcomes. Equal result and source values separate the strict carry test of add and subtract from the less-or-equal test of the extend classes. Words whose upper bits are noisy while the low byte or halfword is fixed show whether the compare classes stay at their own width. Runs of extend operations with `zprev_i` low, next to the same operands with it high, show that Z is sticky. Bursts of unknown codes, and requests interleaved with idle cycles, check the strobe length and the hold behaviour.

// File: rtl/lazy_ccr_eval.sv
module lazy_ccr_eval #(
  parameter int DW = 32,
  parameter int KW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eval_i,
  input  logic [KW-1:0] kind_i,
  input  logic [DW-1:0] res_i,
  input  logic [DW-1:0] src_i,
  input  logic          zprev_i,
  output logic [4:0]    ccr_o,
  output logic          bad_kind_o
);

  localparam int MSB = DW - 1;
  localparam logic [KW-1:0] K_PASS  = KW'(0);
  localparam logic [KW-1:0] K_LOGIC = KW'(1);
  localparam logic [KW-1:0] K_ADD   = KW'(2);
  localparam logic [KW-1:0] K_SUB   = KW'(3);
  localparam logic [KW-1:0] K_CMP8  = KW'(4);
  localparam logic [KW-1:0] K_CMP16 = KW'(5);
  localparam logic [KW-1:0] K_ADDX  = KW'(6);
  localparam logic [KW-1:0] K_SUBX  = KW'(7);
  localparam logic [KW-1:0] K_SHIFT = KW'(8);

  // full-width reconstruction
  logic [DW-1:0] add_a, addx_a, sub_a, subx_a;
  logic [DW-1:0] add_vv, addx_vv, sub_vv, subx_vv;
  assign add_a   = res_i - src_i;
  assign addx_a  = res_i - src_i - DW'(1);
  assign sub_a   = res_i + src_i;
  assign subx_a  = res_i + src_i + DW'(1);
  assign add_vv  = (src_i ^ res_i) & ~(add_a ^ src_i);
  assign addx_vv = (src_i ^ res_i) & ~(addx_a ^ src_i);
  assign sub_vv  = (sub_a ^ res_i) & (sub_a ^ src_i);
  assign subx_vv = (subx_a ^ res_i) & (subx_a ^ src_i);

  logic n_w, z_w;
  assign z_w = (res_i == '0);
  assign n_w = res_i[MSB];

  // narrow compares
  logic [7:0]  r8, s8, a8, v8;
  logic [15:0] r16, s16, a16, v16;
  assign r8  = res_i[7:0];
  assign s8  = src_i[7:0];
  assign a8  = r8 + s8;
  assign v8  = (a8 ^ r8) & (a8 ^ s8);
  assign r16 = res_i[15:0];
  assign s16 = src_i[15:0];
  assign a16 = r16 + s16;
  assign v16 = (a16 ^ r16) & (a16 ^ s16);

  logic [3:0] nzvc;
  logic       bad_c;

  always_comb begin
    nzvc  = 4'b0000;
    bad_c = 1'b0;
    case (kind_i)
      K_PASS:  nzvc = res_i[3:0];
      K_LOGIC: nzvc = {n_w, z_w, 2'b00};
      K_ADD:   nzvc = {n_w, z_w, add_vv[MSB], res_i < src_i};
      K_SUB:   nzvc = {n_w, z_w, sub_vv[MSB], sub_a < src_i};
      K_CMP8:  nzvc = {r8[7], r8 == 8'h00, v8[7], a8 < s8};
      K_CMP16: nzvc = {r16[15], r16 == 16'h0000, v16[15], a16 < s16};
      K_ADDX:  nzvc = {n_w, z_w & zprev_i, addx_vv[MSB], res_i <= src_i};
      K_SUBX:  nzvc = {n_w, z_w & zprev_i, subx_vv[MSB], subx_a <= src_i};
      K_SHIFT: nzvc = {n_w, z_w, 1'b0, src_i != '0};
      default: bad_c = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ccr_o      <= 5'b00000;
      bad_kind_o <= 1'b0;
    end else begin
      bad_kind_o <= eval_i & bad_c;
      if (eval_i) ccr_o <= {1'b0, nzvc};
    end
  end

endmodule

module lazy_ccr_eval_chk #(
  parameter int DW = 32,
  parameter int KW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          eval_i,
  input logic [KW-1:0] kind_i,
  input logic [DW-1:0] res_i,
  input logic [DW-1:0] src_i,
  input logic          zprev_i,
  input logic [4:0]    ccr_o,
  input logic          bad_kind_o
);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_i |=> $stable(ccr_o));

  assert_nz_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && kind_i != KW'(0)) |=> !(ccr_o[3] && ccr_o[2]));

  assert_logic_vc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && kind_i == KW'(1)) |=> (ccr_o[1:0] == 2'b00));

  assert_shift_carry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && kind_i == KW'(8)) |=> (ccr_o[0] == $past(src_i != '0)));

  assert_sticky_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && !zprev_i && (kind_i == KW'(6) || kind_i == KW'(7))) |=> !ccr_o[2]);

  assert_bad_kind_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && kind_i > KW'(8)) |=> (bad_kind_o && ccr_o == 5'b00000));

  assert_strobe_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bad_kind_o |-> $past(eval_i));

endmodule

bind lazy_ccr_eval lazy_ccr_eval_chk #(.DW(DW), .KW(KW)) u_chk (.*);

// File: tb/test_lazy_ccr_eval.sv
module test_lazy_ccr_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eval_i = 1'b0;
  logic [3:0]  kind_i = '0;
  logic [31:0] res_i = '0;
  logic [31:0] src_i = '0;
  logic        zprev_i = 1'b0;
  logic [4:0]  ccr_o;
  logic        bad_kind_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lazy_ccr_eval #(.DW(32), .KW(4)) i_lazy_ccr_eval (
    .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .kind_i(kind_i),
    .res_i(res_i), .src_i(src_i), .zprev_i(zprev_i),
    .ccr_o(ccr_o), .bad_kind_o(bad_kind_o));

  function automatic string req_of(input logic [3:0] k);
    case (k)
      4'd0: return "R3";   4'd1: return "R4";  4'd2: return "R5";
      4'd3: return "R6";   4'd4: return "R7";  4'd5: return "R7";
      4'd6: return "R8";   4'd7: return "R9";  4'd8: return "R10";
      default: return "R12";
    endcase
  endfunction

  // signed overflow of a + b at width w (w <= 32)
  function automatic logic ovf(input logic [31:0] a, input logic [31:0] b,
                               input logic [31:0] s, input int w);
    return (a[w-1] == b[w-1]) && (s[w-1] != a[w-1]);
  endfunction

  function automatic logic [4:0] model(input logic [3:0] k, input logic [31:0] r,
                                       input logic [31:0] s, input logic zp);
    logic [32:0] wide;
    logic [31:0] op1, ns;
    logic n, z, v, c;
    int w;
    w = (k == 4'd4) ? 8 : (k == 4'd5) ? 16 : 32;
    op1 = '0; v = 1'b0; c = 1'b0;
    z = ((r << (32 - w)) == 32'd0);
    n = r[w-1];
    case (k)
      4'd0: return {1'b0, r[3:0]};
      4'd1: ;
      4'd2, 4'd6: begin
        op1  = r - s - ((k == 4'd6) ? 32'd1 : 32'd0);
        wide = {1'b0, op1} + {1'b0, s} + ((k == 4'd6) ? 33'd1 : 33'd0);
        c = wide[32];
        v = ovf(op1, s, r, 32);
        if (k == 4'd6) z = z & zp;
      end
      4'd3, 4'd4, 4'd5, 4'd7: begin
        op1 = r + s + ((k == 4'd7) ? 32'd1 : 32'd0);
        if (w < 32) begin
          op1 = op1 & ((32'd1 << w) - 1);
          c = op1 < (s & ((32'd1 << w) - 1));
        end else begin
          wide = {1'b0, s} + ((k == 4'd7) ? 33'd1 : 33'd0);
          c = ({1'b0, op1} < wide);
        end
        ns = ~s + 32'd1;
        v = ovf(op1, ns, r, w) || (op1[w-1] != s[w-1] && r[w-1] != op1[w-1]);
        v = (op1[w-1] != s[w-1]) && (r[w-1] != op1[w-1]);
        if (k == 4'd7) z = z & zp;
      end
      4'd8: c = (s != 32'd0);
      default: return 5'b00000;
    endcase
    return {1'b0, n, z, v, c};
  endfunction

  task automatic check(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] k, input logic [31:0] r,
                       input logic [31:0] s, input logic zp);
    logic [4:0] e;
    e = model(k, r, s, zp);
    @(negedge clk);
    eval_i = 1'b1; kind_i = k; res_i = r; src_i = s; zprev_i = zp;
    @(negedge clk);
    eval_i = 1'b0;
    check(ccr_o == e, req_of(k), 32'(ccr_o), 32'(e));
    check(bad_kind_o == (k > 4'd8), "R12", 32'(bad_kind_o), 32'(k > 4'd8));
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 5))
      0: return $urandom_range(0, 3);
      1: return 32'h8000_0000 - 32'($urandom_range(0, 2));
      2: return 32'hFFFF_FFFF - 32'($urandom_range(0, 2));
      3: return {$urandom, 8'h00} | 32'($urandom_range(0, 1));
      default: return $urandom;
    endcase
  endfunction

  initial begin
    logic [4:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(ccr_o == 5'd0 && bad_kind_o == 1'b0, "R1", 32'(ccr_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ccr_o == 5'd0, "R1", 32'(ccr_o), 32'd0);

    // R3 copy class and packing
    apply(4'd0, 32'hFFFF_FFF5, 32'd0, 1'b0);
    apply(4'd0, 32'h0000_000A, 32'd7, 1'b1);
    // R4 logic
    apply(4'd1, 32'd0, 32'hFFFF_FFFF, 1'b0);
    apply(4'd1, 32'h8000_0000, 32'd1, 1'b0);
    // R5 add: carry out and signed overflow
    apply(4'd2, 32'd0, 32'd1, 1'b0);
    apply(4'd2, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0);
    apply(4'd2, 32'd5, 32'd5, 1'b0);
    // R6 subtract: borrow and overflow
    apply(4'd3, 32'hFFFF_FFFF, 32'd1, 1'b0);
    apply(4'd3, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0);
    apply(4'd3, 32'd0, 32'd9, 1'b0);
    // R7 compare widths with noisy upper bits
    apply(4'd4, 32'hABCD_EF00, 32'h1234_5601, 1'b0);
    apply(4'd4, 32'h0000_0080, 32'hFFFF_FF7F, 1'b0);
    apply(4'd5, 32'h5555_0000, 32'hAAAA_0001, 1'b0);
    apply(4'd5, 32'h0000_8000, 32'h0000_7FFF, 1'b0);
    // R8 / R9 equality separates <= from <
    apply(4'd6, 32'd7, 32'd7, 1'b1);
    apply(4'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    // R11 sticky zero
    apply(4'd6, 32'd0, 32'd0, 1'b0);
    apply(4'd6, 32'd0, 32'd0, 1'b1);
    apply(4'd7, 32'd0, 32'd3, 1'b0);
    apply(4'd7, 32'd0, 32'd3, 1'b1);
    apply(4'd3, 32'd0, 32'd3, 1'b0);
    // R10 shift
    apply(4'd8, 32'd0, 32'd0, 1'b0);
    apply(4'd8, 32'h8000_0000, 32'd1, 1'b0);
    // R12 unknown code, then strobe drops
    apply(4'd1, 32'h8000_0000, 32'd0, 1'b0);
    apply(4'd9, 32'hFFFF_FFFF, 32'd1, 1'b1);
    @(negedge clk);
    check(bad_kind_o == 1'b0, "R12", 32'(bad_kind_o), 32'd0);
    apply(4'd15, 32'd0, 32'd0, 1'b1);

    // R2 hold while idle
    apply(4'd2, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0);
    held = ccr_o;
    for (int i = 0; i < 8; i++) begin
      kind_i = 4'($urandom_range(0, 15)); res_i = $urandom; src_i = $urandom;
      zprev_i = 1'($urandom);
      @(negedge clk);
      check(ccr_o == held, "R2", 32'(ccr_o), 32'(held));
    end

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] k;
      k = ($urandom_range(0, 19) == 0) ? 4'($urandom_range(9, 15))
                                        : 4'($urandom_range(0, 8));
      apply(k, pick(), pick(), 1'($urandom));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule